// File: doc/BRIEF.md
# Lockable Control Register Bank

This block is a small memory-mapped register bank that holds the configuration word for a device-configuration controller. It presents three word registers on a simple 32-bit register bus: a control word, a set-only freeze register and a write-only key register. Each freeze bit protects one group of control fields, so that later control writes leave that group as it was. Only reset clears a freeze bit.

The key register gates the whole bank. A write of the magic key value raises control bit 27 and the three-bit crypto-enable field, and the bank stays reachable. A write of any other value clears bit 27 and the crypto-enable field, and then closes the bank. While the bank is closed, every write is dropped and every read returns zero. Only reset reopens it. The control word drives the `ctrl_q` output, and the open or closed state drives the `window_open` output. A control write that leaves the crypto-enable field mixed raises a one-cycle `aes_mix_pulse`. A mixed field is any value other than all zeros or all ones.

Top module: `cfg_lock_regs`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ctrl_q` equals 0x0C006000, meaning bits 27, 26, 14 and 13 are set. The freeze register reads 0, `window_open` is 1 and `aes_mix_pulse` is 0. `req_ready` is 1 from the first cycle after reset.
- R2: A write to the freeze register (byte offset 0x04) ORs bits 4:0 of the write data into its current value. Write-data bits 31:5 are ignored, a read returns the five bits in 4:0 with zeros above, and no write can clear a bit.
- R3: A control write (byte offset 0x00) with no freeze bit set stores write-data bits 30:0. Bit 31 is accepted but always reads and drives 0.
- R4: Each freeze bit protects one group of control fields. Bit 0 protects ctrl[6:0], bit 1 protects ctrl[7], bit 2 protects ctrl[8], bit 3 protects ctrl[11:9] and bit 4 protects ctrl[12]. A control write keeps the old value in every protected field, and every other field takes the written value.
- R5: A write of 0x757BDF0D to the key register (byte offset 0x34) sets ctrl[27] and ctrl[11:9] even if freeze bits are set. It changes no other control bit, and `window_open` stays 1.
- R6: A write of any other value to the key register clears ctrl[27] and ctrl[11:9] and changes no other control bit. `window_open` is 0 from the next cycle.
- R7: While `window_open` is 0, writes change nothing, including a key write with the magic value. Reads return 0, and responses are still given.
- R8: A control write whose stored result in ctrl[11:9] is neither 000 nor 111 raises `aes_mix_pulse` for exactly the cycle in which the response is given. Any other request leaves it low.
- R9: Every request accepted while `req_valid` and `req_ready` are both high gives `rsp_valid` for one cycle, the cycle after acceptance. Read data is the register value before that cycle's update, and write responses carry zero data.
- R10: Requests to an unmapped offset or a non-word-aligned address (`req_addr[1:0]` not 0) change no state and read 0. The key register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| ctrl_q | output | 32 | Current control word |
| window_open | output | 1 | Bank reachable |
| aes_mix_pulse | output | 1 | Mixed crypto-enable field after a control write |

## Verification
Two functions act in the same cycle on a control write: field freezing and the mixed-field check. The check must judge the value after freezing, not the raw write data. The bench first stores 111 in the crypto-enable field, sets freeze bit 3, then writes the pattern 010 to that field. It expects no pulse and an unchanged field. A second case writes a mixed value into an unfrozen field and expects a pulse, so that the freezing path is judged apart from the detector.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FRZ_W   = 5;
  localparam int unsigned OFF_CTL = 'h00;
  localparam int unsigned OFF_FRZ = 'h04;
  localparam int unsigned OFF_KEY = 'h34;
  localparam int unsigned AES_LO  = 9;
  localparam int unsigned AES_W   = 3;
  localparam int unsigned PR_BIT  = 27;
  localparam int unsigned DEAD_BIT = 31;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic ctl;
    logic frz;
    logic key;
  } sel_t;

  // fields protected by each freeze bit, index = freeze bit
  localparam word_t GROUP_MASK [FRZ_W] = '{
    32'h0000_007F, 32'h0000_0080, 32'h0000_0100, 32'h0000_0E00, 32'h0000_1000
  };

  function automatic word_t freeze_mask(input logic [FRZ_W-1:0] frz);
    word_t m;
    m = '0;
    for (int i = 0; i < FRZ_W; i++) begin
      if (frz[i]) m = m | GROUP_MASK[i];
    end
    return m;
  endfunction
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  logic aligned;

  always_comb begin
    aligned = (addr[1:0] == 2'b00);
    sel.ctl = aligned && (addr == ADDR_W'(OFF_CTL));
    sel.frz = aligned && (addr == ADDR_W'(OFF_FRZ));
    sel.key = aligned && (addr == ADDR_W'(OFF_KEY));
  end
endmodule

// File: rtl/cfg_lock_sticky.sv
module cfg_lock_sticky #(
  parameter int unsigned NBITS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NBITS-1:0] wbits,
  output logic [NBITS-1:0] bits_q
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                    bits_q[i] <= 1'b0;
      else if (wr_en && wbits[i]) bits_q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter word_t CTRL_RST = 32'h0C00_6000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  word_t            wdata,
  input  logic             key_en,
  input  logic             key_ok,
  input  logic [FRZ_W-1:0] frz,
  output word_t            ctrl_q,
  output logic             mix_q
);
  localparam word_t AES_MASK = word_t'(((1 << AES_W) - 1) << AES_LO);
  localparam word_t KEY_MASK = AES_MASK | (word_t'(1) << PR_BIT);

  word_t              keep;
  word_t              merged;
  logic [AES_W-1:0]   aes_new;

  always_comb begin
    keep             = freeze_mask(frz);
    merged           = (wdata & ~keep) | (ctrl_q & keep);
    merged[DEAD_BIT] = 1'b0;
    aes_new          = merged[AES_LO +: AES_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      mix_q  <= 1'b0;
    end else begin
      mix_q <= 1'b0;
      if (wr_en) begin
        ctrl_q <= merged;
        mix_q  <= (aes_new != '0) && (aes_new != '1);
      end else if (key_en) begin
        ctrl_q <= key_ok ? (ctrl_q | KEY_MASK) : (ctrl_q & ~KEY_MASK);
      end
    end
  end
endmodule

// File: rtl/cfg_lock_gate.sv
module cfg_lock_gate (
  input  logic clk,
  input  logic rst,
  input  logic key_en,
  input  logic key_ok,
  output logic open_q
);
  always_ff @(posedge clk) begin
    if (rst)                   open_q <= 1'b1;
    else if (key_en && !key_ok) open_q <= 1'b0;
  end
endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] KEY_WORD = 32'h757B_DF0D,
  parameter logic [31:0] CTRL_RST = 32'h0C00_6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [31:0]       ctrl_q,
  output logic              window_open,
  output logic              aes_mix_pulse
);
  localparam int unsigned PAD_W = WORD_W - FRZ_W;

  sel_t             sel;
  logic             accept;
  logic             wr_ok;
  logic             key_ok;
  logic [FRZ_W-1:0] lock_q;
  word_t            rd_mux;

  cfg_lock_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  always_comb begin
    accept = req_valid && req_ready;
    wr_ok  = accept && req_write && window_open;
    key_ok = (req_wdata == KEY_WORD);
    if (sel.ctl)      rd_mux = ctrl_q;
    else if (sel.frz) rd_mux = {{PAD_W{1'b0}}, lock_q};
    else              rd_mux = '0;
  end

  cfg_lock_sticky #(.NBITS(FRZ_W)) u_frz (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ok && sel.frz),
    .wbits  (req_wdata[FRZ_W-1:0]),
    .bits_q (lock_q)
  );

  cfg_lock_ctrl #(.CTRL_RST(CTRL_RST)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_ok && sel.ctl),
    .wdata  (req_wdata),
    .key_en (wr_ok && sel.key),
    .key_ok (key_ok),
    .frz    (lock_q),
    .ctrl_q (ctrl_q),
    .mix_q  (aes_mix_pulse)
  );

  cfg_lock_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .key_en (wr_ok && sel.key),
    .key_ok (key_ok),
    .open_q (window_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      rsp_rdata <= (accept && !req_write && window_open) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cfg_lock_regs_chk.sv
module cfg_lock_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [31:0] ctrl_q,
  input logic        window_open,
  input logic        aes_mix_pulse,
  input logic [4:0]  lock_q
);
  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    ((lock_q & $past(lock_q)) == $past(lock_q)));

  assert_frz_sec_R4: assert property (@(posedge clk) disable iff (rst)
    lock_q[1] |=> $stable(ctrl_q[7]));

  assert_frz_seu_R4: assert property (@(posedge clk) disable iff (rst)
    lock_q[2] |=> $stable(ctrl_q[8]));

  assert_closed_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    !window_open |=> ($stable(ctrl_q) && !window_open));

  assert_closed_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!window_open && rsp_valid) |-> (rsp_rdata == 32'h0));

  assert_mix_field_R8: assert property (@(posedge clk) disable iff (rst)
    aes_mix_pulse |-> (rsp_valid && ctrl_q[11:9] != 3'b000 && ctrl_q[11:9] != 3'b111));

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_bit31_dead_R3: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[31]);
endmodule

bind cfg_lock_regs cfg_lock_regs_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_rdata     (rsp_rdata),
  .ctrl_q        (ctrl_q),
  .window_open   (window_open),
  .aes_mix_pulse (aes_mix_pulse),
  .lock_q        (lock_q)
);

// File: tb/cfg_lock_regs_tb.sv
module cfg_lock_regs_tb;
  localparam logic [31:0] KEY  = 32'h757B_DF0D;
  localparam logic [31:0] RSTV = 32'h0C00_6000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] ctrl_q;
  logic        window_open;
  logic        aes_mix_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic        last_pulse;
  logic        last_rvalid;
  logic [31:0] last_rdata;

  always #4 clk = ~clk;

  cfg_lock_regs u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctrl_q(ctrl_q),
    .window_open(window_open), .aes_mix_pulse(aes_mix_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    last_pulse  = aes_mix_pulse;
    last_rvalid = rsp_valid;
    last_rdata  = rsp_rdata;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ctrl_q during first cycle", ctrl_q, RSTV);
    @(negedge clk);
    check("R1 req_ready", {31'b0, req_ready}, 32'd1);
    check("R1 window_open", {31'b0, window_open}, 32'd1);
    check("R1 pulse idle", {31'b0, aes_mix_pulse}, 32'd0);
    bus(1'b0, 8'h04, 0);
    check("R1 lock reads 0", last_rdata, 32'h0);
    bus(1'b0, 8'h00, 0);
    check("R1 ctrl reads reset", last_rdata, RSTV);
  endtask

  task automatic t_plain_ctrl();
    do_reset();
    bus(1'b1, 8'h00, 32'hFFFF_FFFF);
    check("R9 write rsp_valid", {31'b0, last_rvalid}, 32'd1);
    check("R9 write rsp zero", last_rdata, 32'h0);
    check("R8 no pulse all-ones", {31'b0, last_pulse}, 32'd0);
    @(negedge clk);
    check("R9 rsp_valid single", {31'b0, rsp_valid}, 32'd0);
    bus(1'b0, 8'h00, 0);
    check("R3 bit31 dropped", last_rdata, 32'h7FFF_FFFF);
    bus(1'b1, 8'h00, 32'h0000_0000);
    check("R8 no pulse zeros", {31'b0, last_pulse}, 32'd0);
    check("R3 ctrl_q zero", ctrl_q, 32'h0);
    bus(1'b1, 8'h00, 32'h0000_0400);
    check("R8 pulse on mixed", {31'b0, last_pulse}, 32'd1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, aes_mix_pulse}, 32'd0);
  endtask

  task automatic t_unmapped();
    do_reset();
    bus(1'b1, 8'h08, 32'hDEAD_BEEF);
    bus(1'b0, 8'h08, 0);
    check("R10 unmapped reads 0", last_rdata, 32'h0);
    bus(1'b1, 8'h01, 32'h0000_0000);
    check("R10 misaligned write ignored", ctrl_q, RSTV);
    bus(1'b1, 8'h05, 32'h0000_001F);
    bus(1'b0, 8'h04, 0);
    check("R10 misaligned lock ignored", last_rdata, 32'h0);
    bus(1'b0, 8'h34, 0);
    check("R10 key reads 0", last_rdata, 32'h0);
    check("R10 window still open", {31'b0, window_open}, 32'd1);
  endtask

  task automatic t_lock();
    do_reset();
    bus(1'b1, 8'h04, 32'h0000_0003);
    bus(1'b1, 8'h04, 32'h0000_0004);
    bus(1'b0, 8'h04, 0);
    check("R2 lock ORs", last_rdata, 32'h7);
    bus(1'b1, 8'h04, 32'hFFFF_FFE0);
    bus(1'b0, 8'h04, 0);
    check("R2 upper and zero bits ignored", last_rdata, 32'h7);
    do_reset();
    bus(1'b1, 8'h00, 32'h0000_0E00);
    bus(1'b1, 8'h04, 32'h0000_0008);
    bus(1'b1, 8'h00, 32'h0000_0400);
    check("R4 R8 frozen field no pulse", {31'b0, last_pulse}, 32'd0);
    check("R4 aes field kept", ctrl_q, 32'h0000_0E00);
    bus(1'b1, 8'h04, 32'h0000_0001);
    bus(1'b1, 8'h00, 32'h0000_107F);
    check("R4 dbg group kept, fuse bit free", ctrl_q, 32'h0000_1E00);
    bus(1'b1, 8'h04, 32'h0000_0016);
    bus(1'b0, 8'h04, 0);
    check("R2 all five set", last_rdata, 32'h1F);
    bus(1'b1, 8'h00, 32'h4000_0000);
    check("R4 all groups frozen", ctrl_q, 32'h4000_1E00);
    bus(1'b1, 8'h04, 32'h0);
    bus(1'b0, 8'h04, 0);
    check("R2 cannot clear", last_rdata, 32'h1F);
  endtask

  task automatic t_key();
    do_reset();
    bus(1'b1, 8'h00, 32'h0000_0055);
    bus(1'b1, 8'h04, 32'h0000_0008);
    bus(1'b1, 8'h34, KEY);
    check("R5 magic sets bits despite lock", ctrl_q, 32'h0800_0E55);
    check("R5 window open", {31'b0, window_open}, 32'd1);
    bus(1'b1, 8'h34, 32'h0000_1234);
    check("R6 bad key clears", ctrl_q, 32'h0000_0055);
    check("R6 window closed", {31'b0, window_open}, 32'd0);
    bus(1'b0, 8'h00, 0);
    check("R7 read zero when closed", last_rdata, 32'h0);
    check("R7 response still given", {31'b0, last_rvalid}, 32'd1);
    bus(1'b1, 8'h00, 32'h0000_0FFF);
    check("R7 write dropped", ctrl_q, 32'h0000_0055);
    bus(1'b1, 8'h34, KEY);
    check("R7 magic ignored when closed", {31'b0, window_open}, 32'd0);
    do_reset();
    check("R1 reset reopens", {31'b0, window_open}, 32'd1);
    check("R1 reset restores ctrl", ctrl_q, RSTV);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_plain_ctrl();
    t_unmapped();
    t_lock();
    t_key();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule